// File: doc/BRIEF.md
# CAN Power-Save Mode Controller

This block holds the power-save state of a CAN protocol controller and gates the controller's activity from that state. It has three modes: normal operation, sleep and stop. The CPU selects a mode by writing a 2-bit mode field. The raw CAN receive line can wake the controller from sleep. The current mode always reads back on a dedicated output.

Stop is the deepest state. It can only be entered from sleep, and only a CPU write of the sleep code leaves it, which returns the block to sleep. While the block is in stop, the protocol core clock enable is low and transmission is held off. Message buffer access and pointer-register reads are refused, and every CPU write except one to the mode field is discarded. Bus activity in stop changes nothing. The surrounding controller uses the gate outputs as qualifiers on its own request paths.

Top module: `can_psave_ctrl`

## Requirements
- R1: After reset the mode output reads 2'b00 (normal) and the core clock enable is high.
- R2: Mode codes are 2'b00 normal, 2'b01 sleep, 2'b11 stop and 2'b10 reserved. A mode-field write of 2'b01 in normal gives sleep on the next clock. A write of 2'b00 in sleep gives normal. A write of 2'b10 never changes the mode.
- R3: A mode-field write of 2'b11 moves the block to stop only when the current mode is sleep. In normal it is ignored and the mode stays 2'b00.
- R4: In stop, only a mode-field write of 2'b01 changes the mode, and the new mode is sleep. Writes of 2'b00, 2'b10 or 2'b11 leave the mode at stop.
- R5: A level change on the receive line while in stop does not change the mode.
- R6: In sleep, a level change on the receive line returns the mode to normal. The change passes a two-flop synchronizer and an edge detector, so the mode output shows normal after the third rising edge that follows the change.
- R7: If a receive-line wake and a stop request (write of 2'b11) reach the block in the same cycle while it is in sleep, the wake wins and the mode becomes normal.
- R8: The core clock enable is low exactly while the mode is stop.
- R9: A transmit request is passed to the transmit-go output only in normal mode. It is held off in sleep and in stop.
- R10: A CPU write to a register other than the mode field is accepted in normal and sleep and discarded in stop.
- R11: In stop, message buffer access requests are refused and reads of pointer registers are refused. Reads of other registers are accepted in every mode.
- R12: An initialization request is accepted only in normal mode. It is ignored in sleep and in stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cpuWrEn | input | 1 | CPU register write strobe |
| cpuWrIsMode | input | 1 | The write targets the power-save mode field |
| cpuWrData | input | 2 | Mode value carried by a mode-field write |
| cpuRdEn | input | 1 | CPU register read strobe |
| cpuRdIsPtr | input | 1 | The read targets one of the pointer registers |
| bufAccReq | input | 1 | Message buffer read or write request |
| txReq | input | 1 | Pending or new transmit request |
| initReq | input | 1 | Request to enter initialization |
| canRx | input | 1 | Raw CAN receive line, idle high |
| curMode | output | 2 | Current mode (readback of the mode field) |
| coreClkEn | output | 1 | Clock enable for the protocol core |
| txGo | output | 1 | Transmit request allowed to proceed |
| regWrAccept | output | 1 | Non-mode register write is accepted |
| regRdAccept | output | 1 | Register read is accepted |
| bufAccGrant | output | 1 | Message buffer access is granted |
| initAccept | output | 1 | Initialization request is accepted |

## Verification
A wrong internal mode appears on curMode on the clock after the faulty transition. In the same cycle it flips the combinational gates (clock enable, transmit, write, buffer, pointer read and init), so it is visible at the ports within one cycle. A synchronizer that is too short or too long shifts the wake by a cycle, and the bench checks the wake edge on each of the three cycles that follow the line change. A lost wake/stop priority leaves curMode at 2'b11 instead of 2'b00 one cycle after the collision.

// File: rtl/psave_pkg.sv
package psave_pkg;

  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    PS_NORMAL = 2'b00,
    PS_SLEEP  = 2'b01,
    PS_RSVD   = 2'b10,
    PS_STOP   = 2'b11
  } psMode_e;

  // strobes from the control FSM to the gating datapath
  typedef struct packed {
    logic inNormal;
    logic inSleep;
    logic inStop;
  } psStrobe_t;

endpackage

// File: rtl/psave_ctrl.sv
module psave_ctrl
  import psave_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuWrEn,
  input  logic              cpuWrIsMode,
  input  logic [MODE_W-1:0] cpuWrData,
  input  logic              wakeEdge,
  output psMode_e           modeQ,
  output psStrobe_t         strb
);

  psMode_e modeD;
  logic    modeWr;
  psMode_e reqMode;

  assign modeWr  = cpuWrEn && cpuWrIsMode;
  assign reqMode = psMode_e'(cpuWrData);

  always_comb begin
    modeD = modeQ;
    unique case (modeQ)
      PS_NORMAL: begin
        if (modeWr && reqMode == PS_SLEEP) modeD = PS_SLEEP;
      end
      PS_SLEEP: begin
        // bus activity has priority over any pending CPU request
        if (wakeEdge)                              modeD = PS_NORMAL;
        else if (modeWr && reqMode == PS_STOP)     modeD = PS_STOP;
        else if (modeWr && reqMode == PS_NORMAL)   modeD = PS_NORMAL;
      end
      PS_STOP: begin
        if (modeWr && reqMode == PS_SLEEP) modeD = PS_SLEEP;
      end
      default: modeD = PS_NORMAL;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modeQ <= PS_NORMAL;
    else       modeQ <= modeD;
  end

  assign strb.inNormal = (modeQ == PS_NORMAL);
  assign strb.inSleep  = (modeQ == PS_SLEEP);
  assign strb.inStop   = (modeQ == PS_STOP);

endmodule

// File: rtl/psave_dpath.sv
module psave_dpath
  import psave_pkg::*;
#(
  parameter int  SYNC_STAGES = 2,
  parameter logic RX_IDLE    = 1'b1
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      canRx,
  input  psStrobe_t strb,
  input  logic      txReq,
  input  logic      cpuWrEn,
  input  logic      cpuWrIsMode,
  input  logic      cpuRdEn,
  input  logic      cpuRdIsPtr,
  input  logic      bufAccReq,
  input  logic      initReq,
  output logic      wakeEdge,
  output logic      coreClkEn,
  output logic      txGo,
  output logic      regWrAccept,
  output logic      regRdAccept,
  output logic      bufAccGrant,
  output logic      initAccept
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   rxPrev;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : gSync
    if (i == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[i] <= RX_IDLE;
        else       syncQ[i] <= canRx;
      end
    end else begin : gNext
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[i] <= RX_IDLE;
        else       syncQ[i] <= syncQ[i-1];
      end
    end
  end

  // the edge detector keeps running in every mode, so an edge seen in
  // stop is consumed there and cannot wake the block later
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxPrev <= RX_IDLE;
    else       rxPrev <= syncQ[LAST];
  end

  assign wakeEdge    = syncQ[LAST] ^ rxPrev;

  assign coreClkEn   = !strb.inStop;
  assign txGo        = txReq && strb.inNormal;
  assign regWrAccept = cpuWrEn && !cpuWrIsMode && !strb.inStop;
  assign regRdAccept = cpuRdEn && !(cpuRdIsPtr && strb.inStop);
  assign bufAccGrant = bufAccReq && !strb.inStop;
  assign initAccept  = initReq && strb.inNormal;

endmodule

// File: rtl/can_psave_ctrl.sv
module can_psave_ctrl
  import psave_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cpuWrEn,
  input  logic       cpuWrIsMode,
  input  logic [1:0] cpuWrData,
  input  logic       cpuRdEn,
  input  logic       cpuRdIsPtr,
  input  logic       bufAccReq,
  input  logic       txReq,
  input  logic       initReq,
  input  logic       canRx,
  output logic [1:0] curMode,
  output logic       coreClkEn,
  output logic       txGo,
  output logic       regWrAccept,
  output logic       regRdAccept,
  output logic       bufAccGrant,
  output logic       initAccept
);

  psMode_e   modeQ;
  psStrobe_t strb;
  logic      wakeEdge;

  psave_ctrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .cpuWrEn     (cpuWrEn),
    .cpuWrIsMode (cpuWrIsMode),
    .cpuWrData   (cpuWrData),
    .wakeEdge    (wakeEdge),
    .modeQ       (modeQ),
    .strb        (strb)
  );

  psave_dpath #(.SYNC_STAGES(SYNC_STAGES)) uDpath (
    .clk         (clk),
    .rstN        (rstN),
    .canRx       (canRx),
    .strb        (strb),
    .txReq       (txReq),
    .cpuWrEn     (cpuWrEn),
    .cpuWrIsMode (cpuWrIsMode),
    .cpuRdEn     (cpuRdEn),
    .cpuRdIsPtr  (cpuRdIsPtr),
    .bufAccReq   (bufAccReq),
    .initReq     (initReq),
    .wakeEdge    (wakeEdge),
    .coreClkEn   (coreClkEn),
    .txGo        (txGo),
    .regWrAccept (regWrAccept),
    .regRdAccept (regRdAccept),
    .bufAccGrant (bufAccGrant),
    .initAccept  (initAccept)
  );

  assign curMode = modeQ;

endmodule

// File: rtl/psave_checker.sv
module psave_checker (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] curMode,
  input logic       cpuRdIsPtr,
  input logic       coreClkEn,
  input logic       txGo,
  input logic       regWrAccept,
  input logic       regRdAccept,
  input logic       bufAccGrant,
  input logic       initAccept
);

  a_r3_stop_only_from_sleep: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == 2'b11 && $past(curMode) != 2'b11) |-> $past(curMode) == 2'b01);

  a_r4_stop_exits_to_sleep: assert property (@(posedge clk) disable iff (!rstN)
    ($past(curMode) == 2'b11 && curMode != 2'b11) |-> curMode == 2'b01);

  a_r2_reserved_never_held: assert property (@(posedge clk) disable iff (!rstN)
    curMode != 2'b10);

  a_r8_clock_off_in_stop: assert property (@(posedge clk) disable iff (!rstN)
    coreClkEn |-> curMode != 2'b11);

  a_r9_tx_only_normal: assert property (@(posedge clk) disable iff (!rstN)
    txGo |-> curMode == 2'b00);

  a_r10_write_lock: assert property (@(posedge clk) disable iff (!rstN)
    regWrAccept |-> curMode != 2'b11);

  a_r11_buffer_blocked: assert property (@(posedge clk) disable iff (!rstN)
    bufAccGrant |-> curMode != 2'b11);

  a_r11_ptr_read_blocked: assert property (@(posedge clk) disable iff (!rstN)
    (regRdAccept && cpuRdIsPtr) |-> curMode != 2'b11);

  a_r12_init_only_normal: assert property (@(posedge clk) disable iff (!rstN)
    initAccept |-> curMode == 2'b00);

endmodule

bind can_psave_ctrl psave_checker uChk (
  .clk         (clk),
  .rstN        (rstN),
  .curMode     (curMode),
  .cpuRdIsPtr  (cpuRdIsPtr),
  .coreClkEn   (coreClkEn),
  .txGo        (txGo),
  .regWrAccept (regWrAccept),
  .regRdAccept (regRdAccept),
  .bufAccGrant (bufAccGrant),
  .initAccept  (initAccept)
);

// File: tb/tb_can_psave_ctrl.sv
`timescale 1ns/1ps
module tb_can_psave_ctrl;

  logic       clk = 1'b0;
  logic       rstN;
  logic       cpuWrEn, cpuWrIsMode, cpuRdEn, cpuRdIsPtr;
  logic [1:0] cpuWrData;
  logic       bufAccReq, txReq, initReq, canRx;
  logic [1:0] curMode;
  logic       coreClkEn, txGo, regWrAccept, regRdAccept, bufAccGrant, initAccept;

  always #5 clk = ~clk;

  can_psave_ctrl dut (
    .clk(clk), .rstN(rstN), .cpuWrEn(cpuWrEn), .cpuWrIsMode(cpuWrIsMode),
    .cpuWrData(cpuWrData), .cpuRdEn(cpuRdEn), .cpuRdIsPtr(cpuRdIsPtr),
    .bufAccReq(bufAccReq), .txReq(txReq), .initReq(initReq), .canRx(canRx),
    .curMode(curMode), .coreClkEn(coreClkEn), .txGo(txGo),
    .regWrAccept(regWrAccept), .regRdAccept(regRdAccept),
    .bufAccGrant(bufAccGrant), .initAccept(initAccept)
  );

  typedef enum {S_MODE, S_CLK, S_TX, S_WR, S_RD, S_BUF, S_INIT} sig_e;
  typedef struct {
    int    due;
    sig_e  sig;
    int    exp;
    string req;
  } item_t;

  item_t sbQ[$];
  int    cyc    = 0;
  int    checks = 0;
  int    fails  = 0;

  function automatic int sample(sig_e s);
    case (s)
      S_MODE:  return int'(curMode);
      S_CLK:   return int'(coreClkEn);
      S_TX:    return int'(txGo);
      S_WR:    return int'(regWrAccept);
      S_RD:    return int'(regRdAccept);
      S_BUF:   return int'(bufAccGrant);
      default: return int'(initAccept);
    endcase
  endfunction

  // monitor: compares due expectations away from the active edge
  always @(negedge clk) begin
    cyc++;
    while (sbQ.size() > 0 && sbQ[0].due <= cyc) begin
      item_t it;
      int    act;
      it  = sbQ.pop_front();
      act = sample(it.sig);
      checks++;
      if (act != it.exp) begin
        fails++;
        $display("FAIL %s: %s actual=%0d expected=%0d", it.req, it.sig.name(), act, it.exp);
      end
    end
  end

  task automatic expectAt(int dly, sig_e s, int v, string r);
    item_t it;
    it.due = cyc + dly;
    it.sig = s;
    it.exp = v;
    it.req = r;
    sbQ.push_back(it);
  endtask

  task automatic go();
    @(negedge clk);
    #2;
  endtask

  task automatic idle();
    cpuWrEn = 0; cpuWrIsMode = 0; cpuWrData = 2'b00;
    cpuRdEn = 0; cpuRdIsPtr = 0; bufAccReq = 0; txReq = 0; initReq = 0;
  endtask

  task automatic wrMode(logic [1:0] v);
    cpuWrEn = 1; cpuWrIsMode = 1; cpuWrData = v;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    rstN = 0; canRx = 1; idle();
    repeat (3) @(posedge clk);
    go();
    rstN = 1;
    expectAt(1, S_MODE, 0, "R1"); expectAt(1, S_CLK, 1, "R1");
    go();

    // R3: stop request from normal is ignored
    wrMode(2'b11); expectAt(1, S_MODE, 0, "R3"); go(); idle();
    // R2: reserved write ignored
    wrMode(2'b10); expectAt(1, S_MODE, 0, "R2"); go(); idle();
    // normal-mode gates
    txReq = 1; initReq = 1; cpuWrEn = 1; bufAccReq = 1;
    expectAt(1, S_TX, 1, "R9"); expectAt(1, S_INIT, 1, "R12");
    expectAt(1, S_WR, 1, "R10"); expectAt(1, S_BUF, 1, "R11");
    go(); idle();
    // R2: normal -> sleep
    wrMode(2'b01); expectAt(1, S_MODE, 1, "R2"); go(); idle();
    // sleep gates
    txReq = 1; initReq = 1; cpuWrEn = 1;
    expectAt(1, S_TX, 0, "R9"); expectAt(1, S_INIT, 0, "R12");
    expectAt(1, S_WR, 1, "R10"); expectAt(1, S_CLK, 1, "R8");
    go(); idle();
    // R3: sleep -> stop
    wrMode(2'b11); expectAt(1, S_MODE, 3, "R3"); go(); idle();
    // stop gates
    txReq = 1; initReq = 1; cpuWrEn = 1; bufAccReq = 1; cpuRdEn = 1; cpuRdIsPtr = 1;
    expectAt(1, S_CLK, 0, "R8"); expectAt(1, S_TX, 0, "R9");
    expectAt(1, S_WR, 0, "R10"); expectAt(1, S_BUF, 0, "R11");
    expectAt(1, S_RD, 0, "R11"); expectAt(1, S_INIT, 0, "R12");
    go(); idle();
    cpuRdEn = 1; expectAt(1, S_RD, 1, "R11"); go(); idle();
    // R5: bus activity in stop does nothing
    canRx = 0;
    for (int i = 1; i <= 5; i++) expectAt(i, S_MODE, 3, "R5");
    repeat (5) go();
    // R4: only 01 leaves stop
    wrMode(2'b00); expectAt(1, S_MODE, 3, "R4"); go(); idle();
    wrMode(2'b10); expectAt(1, S_MODE, 3, "R4"); go(); idle();
    wrMode(2'b11); expectAt(1, S_MODE, 3, "R4"); go(); idle();
    wrMode(2'b01); expectAt(1, S_MODE, 1, "R4"); expectAt(1, S_CLK, 1, "R8"); go(); idle();
    // sleep after stop: buffers and writes reopen
    bufAccReq = 1; cpuWrEn = 1;
    expectAt(1, S_BUF, 1, "R11"); expectAt(1, S_WR, 1, "R10");
    go(); idle();
    // R6: wake from sleep, three-edge latency
    canRx = 1;
    expectAt(1, S_MODE, 1, "R6"); expectAt(2, S_MODE, 1, "R6"); expectAt(3, S_MODE, 0, "R6");
    repeat (3) go();
    // R2: sleep -> normal by write
    wrMode(2'b01); go(); idle();
    wrMode(2'b00); expectAt(1, S_MODE, 0, "R2"); go(); idle();
    // R7: wake collides with stop request
    wrMode(2'b01); expectAt(1, S_MODE, 1, "R7"); go(); idle();
    canRx = 0;
    go(); go();
    wrMode(2'b11);
    expectAt(1, S_MODE, 0, "R7");
    go(); idle();
    expectAt(1, S_MODE, 0, "R7");
    go();
    repeat (3) go();
    if (sbQ.size() != 0) begin
      checks++; fails++;
      $display("FAIL scoreboard: pending actual=%0d expected=0", sbQ.size());
    end
    summary();
    $finish;
  end

endmodule